// File: doc/BRIEF.md
# I2C Controller Register Front End

This block is the software-facing register layer of an I2C controller. A simple 16-bit register bus (address, write strobe, read strobe, write data, combinational read data) reaches a control register, an interrupt-enable register, an 8-bit transmit byte buffer, an 8-bit receive byte buffer and a status/flag register. A separate serial engine, not part of this block, supplies event pulses, status levels and received bytes. It takes transmit bytes from this block.

The flags follow different clearing rules. The six protocol event flags are sticky and are cleared by writing 1. The receive-full flag clears when software reads the receive buffer. The transmit-empty flag clears when software writes the transmit buffer. Four further bits show live engine and bus-line levels without latching them. A module enable drives the engine's clock enable. Setting the enable from 0 to 1 always performs a soft reset of the flags and buffers. A single interrupt line is raised when any flag is set and its enable bit is also set.

Top module: `i2c_regfront`

## Requirements
- R1: After reset every register reads 0x0000, `eng_clk_en` is 0 and `irq` is 0.
- R2: The address map is 0 control, 1 transmit buffer, 2 receive buffer, 3 flags, 4 interrupt enable. Control bit 0 is the enable and reads back. Control bit 1 (soft reset) always reads 0.
- R3: The transmit and receive buffers hold their byte in bits 7:0, and bits 15:8 read 0.
- R4: Flag register bit positions are: 0 transmit-empty, 1 receive-full, 2 error, 3 start, 4 stop, 5 NACK, 6 general-call, 7 byte-end, 9 transmit mode, 10 busy, 11 SCL low, 12 SDA low. Bits 8 and 15:13 read 0. Engine event input `eng_evt[i]` sets flag bit i+2.
- R5: Flag bits 7:2 are sticky. Writing 1 to one of them at address 3 clears it, writing 0 leaves it unchanged, and writes to bits 1:0 have no effect.
- R6: If a flag's set event and a clearing action (write-1, receive read, transmit write) occur in the same cycle, the flag ends up set.
- R7: `eng_rx_push` loads `eng_rx_byte` into the receive buffer and sets receive-full. A bus read of address 2 clears receive-full.
- R8: `eng_tx_take` sets transmit-empty and drops `eng_tx_pending`. A bus write to address 1 while transmit-empty is 1 loads the byte onto `eng_tx_byte`, clears transmit-empty and raises `eng_tx_pending`. While transmit-empty is 0, such a write is ignored.
- R9: Flag bits 12/11 read 1 while `line_sda`/`line_scl` is low. Bits 10/9 follow `eng_busy`/`eng_xmit`. All four show their input in the same cycle.
- R10: `eng_clk_en` equals control bit 0. While it is 0, event pulses, `eng_rx_push` and `eng_tx_take` are ignored.
- R11: A control write that takes the enable from 0 to 1, or that sets bit 1, clears all flags and both buffers on that clock edge. It leaves the interrupt-enable register unchanged.
- R12: `irq` is the OR of flag bits 7:0 each ANDed with the same bit of the interrupt-enable register at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (drives read side effects) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| eng_clk_en | output | 1 | Clock enable to the serial engine |
| eng_evt | input | 6 | Event pulses: error, start, stop, NACK, general-call, byte-end |
| eng_busy | input | 1 | Engine busy level |
| eng_xmit | input | 1 | Engine transmit-mode level |
| line_sda | input | 1 | Sampled SDA line level |
| line_scl | input | 1 | Sampled SCL line level |
| eng_tx_take | input | 1 | Engine has taken the transmit byte |
| eng_tx_byte | output | 8 | Transmit byte to the engine |
| eng_tx_pending | output | 1 | A written byte awaits the engine |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| irq | output | 1 | Combined interrupt |

## Verification
A table of event and write-1 patterns drives the sticky flags. It includes single events, several events at once, partial clears, a clear that races its own set, and writes to the two hardware-owned bits. Together these separate correct per-bit masking and the set-over-clear priority from a shared or inverted clear. Directed sequences then cover the buffer handshakes: a transmit write rejected before and after an accepted one, and a receive read in the same cycle as a push. Further sequences cover the live line bits, interrupt masking, and the two soft-reset triggers. Finally, stimulus applied while the module is disabled must leave the flags untouched.

// File: rtl/i2c_regfront_pkg.sv
package i2c_regfront_pkg;
  localparam int ADDR_W = 3;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;
  localparam int N_EVT  = 6;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;

  localparam int FB_TBE  = 0;
  localparam int FB_RBF  = 1;
  localparam int FB_EVT0 = 2;
  localparam int FB_MODE = 9;
  localparam int FB_BUSY = 10;
  localparam int FB_SCL  = 11;
  localparam int FB_SDA  = 12;
  localparam int IRQ_W   = FB_EVT0 + N_EVT;
endpackage

// File: rtl/i2c_rf_ctrl.sv
module i2c_rf_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wbit_en,
  input  logic wbit_srst,
  output logic en_o,
  output logic srst_o
);
  logic en_q, en_d;

  always_comb begin
    en_d   = en_q;
    srst_o = 1'b0;
    if (wr_ctrl) begin
      en_d   = wbit_en;
      srst_o = wbit_srst | (wbit_en & ~en_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  // R10
  en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (en_q == $past(wbit_en)));
endmodule

// File: rtl/i2c_rf_bufs.sv
module i2c_rf_bufs #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              en,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rx_rd,
  input  logic              tx_take,
  input  logic              rx_push,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] txd_o,
  output logic [BYTE_W-1:0] rxd_o,
  output logic              tbe_o,
  output logic              rbf_o,
  output logic              pend_o
);
  logic [BYTE_W-1:0] txd_q, txd_d, rxd_q, rxd_d;
  logic tbe_q, tbe_d, rbf_q, rbf_d, pend_q, pend_d;
  logic tx_accept, take_ok, push_ok;

  assign tx_accept = tx_wr & tbe_q;
  assign take_ok   = tx_take & en;
  assign push_ok   = rx_push & en;

  always_comb begin
    txd_d  = txd_q;
    rxd_d  = rxd_q;
    tbe_d  = tbe_q;
    rbf_d  = rbf_q;
    pend_d = pend_q;
    if (srst) begin
      txd_d  = '0;
      rxd_d  = '0;
      tbe_d  = 1'b0;
      rbf_d  = 1'b0;
      pend_d = 1'b0;
    end else begin
      if (tx_accept) txd_d = wr_byte;
      if (take_ok) begin
        tbe_d  = 1'b1;
        pend_d = 1'b0;
      end else if (tx_accept) begin
        tbe_d  = 1'b0;
        pend_d = 1'b1;
      end
      if (push_ok) begin
        rxd_d = rx_byte;
        rbf_d = 1'b1;
      end else if (rx_rd) begin
        rbf_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q  <= '0;
      rxd_q  <= '0;
      tbe_q  <= 1'b0;
      rbf_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      txd_q  <= txd_d;
      rxd_q  <= rxd_d;
      tbe_q  <= tbe_d;
      rbf_q  <= rbf_d;
      pend_q <= pend_d;
    end
  end

  assign txd_o  = txd_q;
  assign rxd_o  = rxd_q;
  assign tbe_o  = tbe_q;
  assign rbf_o  = rbf_q;
  assign pend_o = pend_q;

  // R8
  tx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tbe_q && !srst) |=> $stable(txd_q));
  // R7
  rbf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rbf_q && !push_ok && !srst) |=> !rbf_q);
  // R6
  rbf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_push && en && !srst) |=> rbf_q);
  // R11
  srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (txd_q == '0 && rxd_q == '0 && !tbe_q && !rbf_q && !pend_q));
endmodule

// File: rtl/i2c_rf_flags.sv
module i2c_rf_flags #(
  parameter int N_EVT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             en,
  input  logic [N_EVT-1:0] ev,
  input  logic             clr_wr,
  input  logic [N_EVT-1:0] clr_mask,
  output logic [N_EVT-1:0] flag_o
);
  logic [N_EVT-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    for (int i = 0; i < N_EVT; i++) begin
      if (srst)                       flag_d[i] = 1'b0;
      else if (en && ev[i])           flag_d[i] = 1'b1;
      else if (clr_wr && clr_mask[i]) flag_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  for (genvar g = 0; g < N_EVT; g++) begin : g_chk
    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ev[g] && !srst) |=> flag_q[g]);
    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !(clr_wr && clr_mask[g]) && !srst) |=> flag_q[g]);
    // R10
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !flag_q[g]) |=> !flag_q[g]);
  end
endmodule

// File: rtl/i2c_regfront.sv
module i2c_regfront
  import i2c_regfront_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              eng_clk_en,
  input  logic [N_EVT-1:0]  eng_evt,
  input  logic              eng_busy,
  input  logic              eng_xmit,
  input  logic              line_sda,
  input  logic              line_scl,
  input  logic              eng_tx_take,
  output logic [BYTE_W-1:0] eng_tx_byte,
  output logic              eng_tx_pending,
  input  logic              eng_rx_push,
  input  logic [BYTE_W-1:0] eng_rx_byte,
  output logic              irq
);
  logic [1:0] rst_sync_q;
  logic rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic wr_ctrl, wr_txd, rd_rxd, wr_flag, wr_ien;
  assign wr_ctrl = bus_we & (bus_addr == A_CTRL);
  assign wr_txd  = bus_we & (bus_addr == A_TXD);
  assign wr_flag = bus_we & (bus_addr == A_FLAG);
  assign wr_ien  = bus_we & (bus_addr == A_IEN);
  assign rd_rxd  = bus_re & (bus_addr == A_RXD);

  logic wdata_unused;
  assign wdata_unused = ^bus_wdata[BUS_W-1:BYTE_W];

  logic en, srst;
  i2c_rf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .wr_ctrl(wr_ctrl),
    .wbit_en(bus_wdata[0]), .wbit_srst(bus_wdata[1]),
    .en_o(en), .srst_o(srst)
  );

  logic [BYTE_W-1:0] txd, rxd;
  logic tbe, rbf;
  i2c_rf_bufs #(.BYTE_W(BYTE_W)) u_bufs (
    .clk(clk), .rst_n(rst_n_s), .srst(srst), .en(en),
    .tx_wr(wr_txd), .wr_byte(bus_wdata[BYTE_W-1:0]), .rx_rd(rd_rxd),
    .tx_take(eng_tx_take), .rx_push(eng_rx_push), .rx_byte(eng_rx_byte),
    .txd_o(txd), .rxd_o(rxd), .tbe_o(tbe), .rbf_o(rbf), .pend_o(eng_tx_pending)
  );

  logic [N_EVT-1:0] evf;
  i2c_rf_flags #(.N_EVT(N_EVT)) u_flags (
    .clk(clk), .rst_n(rst_n_s), .srst(srst), .en(en), .ev(eng_evt),
    .clr_wr(wr_flag), .clr_mask(bus_wdata[FB_EVT0 +: N_EVT]), .flag_o(evf)
  );

  logic [IRQ_W-1:0] ien_q, ien_d;
  always_comb begin
    ien_d = ien_q;
    if (wr_ien) ien_d = bus_wdata[IRQ_W-1:0];
  end
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ien_q <= '0;
    else          ien_q <= ien_d;
  end

  logic [BUS_W-1:0] flag_word;
  always_comb begin
    flag_word               = '0;
    flag_word[FB_TBE]       = tbe;
    flag_word[FB_RBF]       = rbf;
    flag_word[FB_EVT0 +: N_EVT] = evf;
    flag_word[FB_MODE]      = eng_xmit;
    flag_word[FB_BUSY]      = eng_busy;
    flag_word[FB_SCL]       = ~line_scl;
    flag_word[FB_SDA]       = ~line_sda;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[0] = en;
      A_TXD:   bus_rdata[BYTE_W-1:0] = txd;
      A_RXD:   bus_rdata[BYTE_W-1:0] = rxd;
      A_FLAG:  bus_rdata = flag_word;
      A_IEN:   bus_rdata[IRQ_W-1:0] = ien_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq         = |(flag_word[IRQ_W-1:0] & ien_q);
  assign eng_clk_en  = en;
  assign eng_tx_byte = txd;

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ien_q == '0) |-> !irq);
  // R11
  ien_keep_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (srst && !wr_ien) |=> $stable(ien_q));
endmodule

// File: tb/test_i2c_regfront.sv
`timescale 1ns/1ps
module test_i2c_regfront;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [2:0] bus_addr;
  logic bus_we, bus_re;
  logic [15:0] bus_wdata, bus_rdata;
  logic eng_clk_en;
  logic [5:0] eng_evt;
  logic eng_busy, eng_xmit, line_sda, line_scl;
  logic eng_tx_take, eng_tx_pending, eng_rx_push, irq;
  logic [7:0] eng_tx_byte, eng_rx_byte;

  i2c_regfront i_i2c_regfront (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_clk_en(eng_clk_en), .eng_evt(eng_evt), .eng_busy(eng_busy),
    .eng_xmit(eng_xmit), .line_sda(line_sda), .line_scl(line_scl),
    .eng_tx_take(eng_tx_take), .eng_tx_byte(eng_tx_byte),
    .eng_tx_pending(eng_tx_pending), .eng_rx_push(eng_rx_push),
    .eng_rx_byte(eng_rx_byte), .irq(irq)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // vector: {events[5:0], write-1 mask[7:0], expected flags[7:0]}
  localparam int NV = 9;
  localparam logic [21:0] VEC [NV] = '{
    {6'b000001, 8'h00, 8'h04},
    {6'b000110, 8'h00, 8'h1C},
    {6'b000000, 8'h08, 8'h14},
    {6'b100000, 8'h14, 8'h80},
    {6'b100000, 8'h80, 8'h80},
    {6'b011000, 8'h83, 8'h60},
    {6'b000000, 8'hFF, 8'h00},
    {6'b111111, 8'h00, 8'hFC},
    {6'b000000, 8'hFC, 8'h00}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic pulse_evt(input logic [5:0] e);
    @(negedge clk); eng_evt = e;
    @(negedge clk); eng_evt = '0;
  endtask

  task automatic take;
    @(negedge clk); eng_tx_take = 1'b1;
    @(negedge clk); eng_tx_take = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_byte = b;
    @(negedge clk); eng_rx_push = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_we = 0; bus_re = 0; bus_wdata = '0;
    eng_evt = '0; eng_busy = 0; eng_xmit = 0; line_sda = 1; line_scl = 1;
    eng_tx_take = 0; eng_rx_push = 0; eng_rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], v); chk("R1 reg after reset", v, 16'h0000);
    end
    chk("R1 clk_en", {15'b0, eng_clk_en}, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);

    // R10 disabled: engine stimulus ignored
    pulse_evt(6'b111111); push(8'hAA); take;
    rd(3'd3, v); chk("R10 flags while disabled", v, 16'h0000);

    wr(3'd0, 16'h0001);
    chk("R10 clk_en on", {15'b0, eng_clk_en}, 16'h0001);
    rd(3'd0, v); chk("R2 ctrl readback", v, 16'h0001);

    // R4 R5 R6 vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      eng_evt = VEC[i][21:16];
      bus_addr = 3'd3; bus_we = 1'b1; bus_wdata = {8'h00, VEC[i][15:8]};
      @(negedge clk);
      eng_evt = '0; bus_we = 1'b0; bus_wdata = '0;
      rd(3'd3, v);
      chk($sformatf("R5 R6 R4 vector %0d", i), v, {8'h00, VEC[i][7:0]});
    end

    // R8 transmit handshake
    wr(3'd1, 16'h005A);
    rd(3'd1, v); chk("R8 write ignored when not empty", v, 16'h0000);
    take;
    rd(3'd3, v); chk("R8 R4 tbe set", v, 16'h0001);
    wr(3'd1, 16'hFF5A);
    rd(3'd1, v); chk("R3 R8 txd loaded", v, 16'h005A);
    rd(3'd3, v); chk("R8 tbe cleared", v, 16'h0000);
    chk("R8 pending/byte", {7'b0, eng_tx_pending, eng_tx_byte}, 16'h015A);
    wr(3'd1, 16'h0033);
    rd(3'd1, v); chk("R8 second write ignored", v, 16'h005A);
    take;
    chk("R8 pending dropped", {15'b0, eng_tx_pending}, 16'h0000);

    // R7 receive handshake
    push(8'hC3);
    rd(3'd3, v); chk("R7 R4 rbf set", v, 16'h0003);
    rd(3'd2, v); chk("R3 R7 rxd value", v, 16'h00C3);
    rd(3'd3, v); chk("R7 rbf cleared by read", v, 16'h0001);
    @(negedge clk);
    bus_addr = 3'd2; bus_re = 1'b1; eng_rx_push = 1'b1; eng_rx_byte = 8'h22;
    @(negedge clk);
    bus_re = 1'b0; eng_rx_push = 1'b0;
    rd(3'd3, v); chk("R6 push beats read clear", v, 16'h0003);
    rd(3'd2, v); chk("R7 rxd newest", v, 16'h0022);

    // R9 live levels
    @(negedge clk); bus_addr = 3'd3; line_sda = 1'b0;
    #1 chk("R9 sda low", bus_rdata & 16'hFE00, 16'h1000);
    line_scl = 1'b0; eng_busy = 1'b1; eng_xmit = 1'b1;
    #1 chk("R9 all live", bus_rdata & 16'hFE00, 16'h1E00);
    line_sda = 1'b1; line_scl = 1'b1; eng_busy = 1'b0; eng_xmit = 1'b0;
    #1 chk("R9 released", bus_rdata & 16'hFE00, 16'h0000);

    // R12 interrupt masking
    wr(3'd4, 16'h0004);
    rd(3'd4, v); chk("R12 ien readback", v, 16'h0004);
    chk("R12 irq masked quiet", {15'b0, irq}, 16'h0000);
    pulse_evt(6'b000001);
    chk("R12 irq on error", {15'b0, irq}, 16'h0001);
    wr(3'd3, 16'h0004);
    chk("R12 irq after clear", {15'b0, irq}, 16'h0000);
    wr(3'd4, 16'h0001);
    chk("R12 irq from tbe", {15'b0, irq}, 16'h0001);
    wr(3'd4, 16'h0010);

    // R11 soft reset via bit 1
    pulse_evt(6'b111111);
    wr(3'd0, 16'h0003);
    rd(3'd3, v); chk("R11 srst clears flags", v, 16'h0000);
    rd(3'd1, v); chk("R11 srst clears txd", v, 16'h0000);
    rd(3'd2, v); chk("R11 srst clears rxd", v, 16'h0000);
    rd(3'd4, v); chk("R11 ien kept", v, 16'h0010);
    rd(3'd0, v); chk("R2 srst bit reads 0", v, 16'h0001);

    // R11 soft reset on re-enable
    pulse_evt(6'b000100);
    chk("R12 irq on stop", {15'b0, irq}, 16'h0001);
    wr(3'd0, 16'h0000);
    chk("R10 clk_en off", {15'b0, eng_clk_en}, 16'h0000);
    pulse_evt(6'b001000);
    rd(3'd3, v); chk("R10 event ignored when off", v, 16'h0010);
    wr(3'd0, 16'h0001);
    rd(3'd3, v); chk("R11 re-enable clears", v, 16'h0000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule